// File: doc/BRIEF.md
# Narrow Mailbox Chunk Sequencer

This engine runs one complete exchange with a device that has a narrow mailbox, seen through a register bus. A narrow mailbox has a single write-data register and a single read-data register. Every dword of a message goes to the same address, one after another. A pulse on `start`, together with a chunk length in dwords, launches the exchange. The engine sends a fixed four-dword request header. It then streams the chunk payload, which it takes from a valid/ready source. Next it writes the GO command to the control register and polls the status register until the device reports ready or error. When the device is ready, the engine drains the four-dword response. After each response read it writes a zero to the read-data register, so the device knows the word was taken.

The result appears on plain status pins. These are a two-bit outcome code, the next offset returned by the device, a flag that shows when that offset is the end-of-staging marker, and a warning for a malformed response header. A polling budget, counted in clock cycles, guards the wait. When the budget runs out, the engine writes ABORT to the control register and reports a timeout. The host chooses the chunk size and steps through a larger image itself. Each run of this block moves one chunk.

Payload back-pressure works as follows. The engine raises `pl_ready` only while it is in the payload phase and its bus port is free. A word transfers on a cycle where `pl_valid` and `pl_ready` are both high. While `pl_valid` is low the engine simply waits. The source must hold `pl_data` steady while `pl_valid` is high.

Top module: `mbox_stager`

## Requirements
- R1: After reset, `busy`, `done`, `bus_req` and `pl_ready` are 0.
- R2: Once `bus_req` rises it stays high, with `bus_we`, `bus_addr` and `bus_wdata` unchanged, until the cycle in which `bus_ack` is high. A cycle with both high completes exactly one transfer. For a read, `bus_rdata` is taken in that cycle.
- R3: A run starts with four writes to address 0x8. The dwords written are, in order: {OBJ_TYPE (default 0x000B) in bits 31:16, VENDOR_ID in bits 15:0}; the chunk length plus 4; 0x3; and 0x0.
- R4: After the header, exactly `chunk_dwords` payload words are taken through the valid/ready port and written to 0x8 in arrival order. A length of 0 skips this phase entirely.
- R5: After the payload, the value 0x8000_0000 (GO, bit 31) is written once to the control address 0x0.
- R6: The engine then reads status at 0x4 repeatedly. Bit 2 (error) ends the run with outcome 3 and no response access. Bit 2 wins over bit 31. Bit 31 (ready) on its own moves the engine to the response phase.
- R7: A status read that shows neither bit, returned once at least `poll_limit` cycles have been spent polling, makes the engine write 0x1 (ABORT, bit 0) to 0x0. The run then ends with outcome 2. A ready status wins over an expired budget.
- R8: The response is four reads of 0xC. Each read is followed by a write of 0 to 0xC before the next bus transfer.
- R9: `next_offset` is the third response dword. `staging_finished` is 1 exactly when that dword is 0xFFFF_FFFF.
- R10: Bit 2 of the fourth response dword gives outcome 1 (fail). Without it the outcome is 0 (ok), whatever bits 0 and 1 hold.
- R11: `hdr_warn` is set when the first response dword differs from the request header word or the second differs from 4. It does not change the outcome.
- R12: `done` is a one-cycle pulse at the end of a run. The results then hold until the next accepted start. A `start` while `busy` is ignored, and the run in progress keeps its latched length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one exchange (taken when idle) |
| chunk_dwords | input | LEN_W | Payload length in dwords, latched at start |
| poll_limit | input | TMR_W | Polling budget in cycles |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| outcome | output | 2 | 0 ok, 1 fail, 2 timeout, 3 device error |
| next_offset | output | 32 | Third response dword |
| staging_finished | output | 1 | next_offset equals 0xFFFF_FFFF |
| hdr_warn | output | 1 | Response header or length mismatch |
| pl_valid | input | 1 | Payload word available |
| pl_ready | output | 1 | Payload word taken when pl_valid is also high |
| pl_data | input | 32 | Payload word |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 4 | Byte address of mailbox register |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer completes this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
The polling budget can run out in the same cycle that a status read returns ready. That collision is forced with a budget of one cycle and a device that answers ready on the first poll, so the first status read completes after the budget has expired. The run must end ok with no ABORT write in the transfer log. A status word with ready and error both set is also sent. It must end with outcome 3 and with no access to the read-data register.

// File: rtl/mbox_stager_pkg.sv
package mbox_stager_pkg;
  localparam int DW = 32;
  localparam int AW = 4;

  localparam logic [AW-1:0] OFS_CTRL  = 4'h0;
  localparam logic [AW-1:0] OFS_STAT  = 4'h4;
  localparam logic [AW-1:0] OFS_WDATA = 4'h8;
  localparam logic [AW-1:0] OFS_RDATA = 4'hC;

  localparam logic [DW-1:0] CTRL_GO    = 32'h8000_0000;
  localparam logic [DW-1:0] CTRL_ABORT = 32'h0000_0001;
  localparam logic [DW-1:0] CMD_LOAD   = 32'h0000_0003;
  localparam logic [DW-1:0] HDR_DWORDS = 32'd4;
  localparam logic [DW-1:0] OFFSET_END = 32'hFFFF_FFFF;

  localparam int STAT_READY_BIT = 31;
  localparam int STAT_ERR_BIT   = 2;
  localparam int FLAG_ERR_BIT   = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR, ST_PAYLOAD, ST_GO, ST_POLL,
    ST_RESP_RD, ST_RESP_ACK, ST_ABORT, ST_DONE
  } stage_e;

  typedef enum logic [1:0] {
    OUT_OK = 2'd0, OUT_FAIL = 2'd1, OUT_TIMEOUT = 2'd2, OUT_DEVERR = 2'd3
  } outcome_e;
endpackage

// File: rtl/mbox_bus_port.sv
module mbox_bus_port
  import mbox_stager_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          fin,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack
);
  assign fin = bus_req && bus_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (fin) begin
      bus_req <= 1'b0;
    end else if (issue && !bus_req) begin
      bus_req   <= 1'b1;
      bus_we    <= we;
      bus_addr  <= addr;
      bus_wdata <= wdata;
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));
endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [TMR_W-1:0] limit,
  output logic             expired
);
  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (run && cnt != '1) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);

  assert_tmr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt));
endmodule

// File: rtl/mbox_resp_decode.sv
module mbox_resp_decode
  import mbox_stager_pkg::*;
#(
  parameter logic [DW-1:0] EXP_HDR = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap,
  input  logic [1:0]    idx,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] next_offset,
  output logic          finished,
  output logic          hdr_warn,
  output logic          err_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      next_offset <= '0;
      hdr_warn    <= 1'b0;
      err_flag    <= 1'b0;
    end else if (cap) begin
      unique case (idx)
        2'd0: if (word != EXP_HDR)    hdr_warn <= 1'b1;
        2'd1: if (word != HDR_DWORDS) hdr_warn <= 1'b1;
        2'd2: next_offset <= word;
        default: err_flag <= word[FLAG_ERR_BIT];
      endcase
    end
  end

  assign finished = (next_offset == OFFSET_END);

  assert_warn_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdr_warn) |-> $past(cap && (idx < 2'd2)));
endmodule

// File: rtl/mbox_stager.sv
module mbox_stager
  import mbox_stager_pkg::*;
#(
  parameter int              LEN_W     = 16,
  parameter int              TMR_W     = 32,
  parameter logic [15:0]     VENDOR_ID = 16'h1AB5,
  parameter logic [15:0]     OBJ_TYPE  = 16'h000B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] chunk_dwords,
  input  logic [TMR_W-1:0] poll_limit,
  output logic             busy,
  output logic             done,
  output logic [1:0]       outcome,
  output logic [31:0]      next_offset,
  output logic             staging_finished,
  output logic             hdr_warn,
  input  logic             pl_valid,
  output logic             pl_ready,
  input  logic [31:0]      pl_data,
  output logic             bus_req,
  output logic             bus_we,
  output logic [3:0]       bus_addr,
  output logic [31:0]      bus_wdata,
  input  logic             bus_ack,
  input  logic [31:0]      bus_rdata
);
  localparam logic [DW-1:0]    HDR_WORD = {OBJ_TYPE, VENDOR_ID};
  localparam logic [LEN_W-1:0] LEN_ONE  = 1;

  stage_e           state;
  outcome_e         outcome_q;
  logic [1:0]       idx;
  logic [LEN_W-1:0] len_q, pl_cnt;
  logic [DW-1:0]    total_len;
  logic             xfer, c_we, issue, fin, expired, err_flag, accept;
  logic [AW-1:0]    c_addr;
  logic [DW-1:0]    c_wdata;

  assign total_len = {{(DW-LEN_W){1'b0}}, len_q} + HDR_DWORDS;
  assign accept    = (state == ST_IDLE) && start;

  always_comb begin
    xfer    = 1'b0;
    c_we    = 1'b1;
    c_addr  = OFS_WDATA;
    c_wdata = '0;
    unique case (state)
      ST_HDR: begin
        xfer = 1'b1;
        unique case (idx)
          2'd0: c_wdata = HDR_WORD;
          2'd1: c_wdata = total_len;
          2'd2: c_wdata = CMD_LOAD;
          default: c_wdata = '0;
        endcase
      end
      ST_PAYLOAD: begin xfer = pl_valid; c_wdata = pl_data; end
      ST_GO:      begin xfer = 1'b1; c_addr = OFS_CTRL; c_wdata = CTRL_GO; end
      ST_POLL:    begin xfer = 1'b1; c_we = 1'b0; c_addr = OFS_STAT; end
      ST_RESP_RD: begin xfer = 1'b1; c_we = 1'b0; c_addr = OFS_RDATA; end
      ST_RESP_ACK:begin xfer = 1'b1; c_addr = OFS_RDATA; end
      ST_ABORT:   begin xfer = 1'b1; c_addr = OFS_CTRL; c_wdata = CTRL_ABORT; end
      default: ;
    endcase
  end

  assign issue    = xfer && !bus_req;
  assign pl_ready = (state == ST_PAYLOAD) && !bus_req;

  mbox_bus_port u_port (
    .clk(clk), .rst_n(rst_n), .issue(issue), .we(c_we), .addr(c_addr), .wdata(c_wdata),
    .fin(fin), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack)
  );

  mbox_poll_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(state == ST_GO), .run(state == ST_POLL),
    .limit(poll_limit), .expired(expired)
  );

  mbox_resp_decode #(.EXP_HDR(HDR_WORD)) u_resp (
    .clk(clk), .rst_n(rst_n), .clr(accept), .cap((state == ST_RESP_RD) && fin),
    .idx(idx), .word(bus_rdata), .next_offset(next_offset),
    .finished(staging_finished), .hdr_warn(hdr_warn), .err_flag(err_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      len_q     <= '0;
      pl_cnt    <= '0;
      outcome_q <= OUT_OK;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          len_q  <= chunk_dwords;
          idx    <= '0;
          pl_cnt <= '0;
          state  <= ST_HDR;
        end
        ST_HDR: if (fin) begin
          if (idx == 2'd3) begin
            idx   <= '0;
            state <= (len_q == '0) ? ST_GO : ST_PAYLOAD;
          end else idx <= idx + 2'd1;
        end
        ST_PAYLOAD: if (fin) begin
          pl_cnt <= pl_cnt + LEN_ONE;
          if (pl_cnt + LEN_ONE == len_q) state <= ST_GO;
        end
        ST_GO: if (fin) state <= ST_POLL;
        ST_POLL: if (fin) begin
          if (bus_rdata[STAT_ERR_BIT]) begin
            outcome_q <= OUT_DEVERR;
            state     <= ST_DONE;
          end else if (bus_rdata[STAT_READY_BIT]) begin
            idx   <= '0;
            state <= ST_RESP_RD;
          end else if (expired) state <= ST_ABORT;
        end
        ST_RESP_RD: if (fin) state <= ST_RESP_ACK;
        ST_RESP_ACK: if (fin) begin
          if (idx == 2'd3) begin
            outcome_q <= err_flag ? OUT_FAIL : OUT_OK;
            state     <= ST_DONE;
          end else begin
            idx   <= idx + 2'd1;
            state <= ST_RESP_RD;
          end
        end
        ST_ABORT: if (fin) begin
          outcome_q <= OUT_TIMEOUT;
          state     <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);
  assign outcome = outcome_q;

  // Protocol trackers that feed the assertions below
  logic rd_owed, abort_sent;
  always_ff @(posedge clk) begin
    if (!rst_n || accept) begin
      rd_owed    <= 1'b0;
      abort_sent <= 1'b0;
    end else if (fin) begin
      if (!bus_we && bus_addr == OFS_RDATA) rd_owed <= 1'b1;
      if (bus_we && bus_addr == OFS_RDATA && bus_wdata == '0) rd_owed <= 1'b0;
      if (bus_we && bus_addr == OFS_CTRL && bus_wdata == CTRL_ABORT) abort_sent <= 1'b1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !pl_ready));
  assert_pl_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && pl_ready) |-> (pl_cnt < len_q));
  assert_go_after_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == OFS_CTRL && bus_wdata == CTRL_GO) |-> (pl_cnt == len_q));
  assert_timeout_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && outcome == OUT_TIMEOUT) |-> abort_sent);
  assert_read_acked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !(rd_owed && !(bus_we && bus_addr == OFS_RDATA)));
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/mbox_stager_tb_top.sv
module mbox_stager_tb_top;
  localparam logic [31:0] HDR = 32'h000B_1AB5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0;
  logic [15:0] chunk_dwords = '0;
  logic [31:0] poll_limit = 32'd1000;
  logic        busy, done, staging_finished, hdr_warn;
  logic [1:0]  outcome;
  logic [31:0] next_offset;
  logic        pl_valid, pl_ready;
  logic [31:0] pl_data;
  logic        bus_req, bus_we, bus_ack;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  mbox_stager dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .chunk_dwords(chunk_dwords),
    .poll_limit(poll_limit), .busy(busy), .done(done), .outcome(outcome),
    .next_offset(next_offset), .staging_finished(staging_finished), .hdr_warn(hdr_warn),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  // Device model and transfer log
  logic        clr_log = 1'b0, stall = 1'b0;
  int          notready_n = 0, poll_n = 0, rd_i = 0, log_n = 0, pl_idx = 0, cyc = 0;
  logic [31:0] stat_final = 32'h8000_0000;
  logic [31:0] resp [4];
  logic        log_we [64];
  logic [3:0]  log_addr [64];
  logic [31:0] log_data [64];

  assign pl_valid = !stall || cyc[1];
  assign pl_data  = 32'hA000_0000 + pl_idx;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr_log) begin
      log_n <= 0; poll_n <= 0; rd_i <= 0; pl_idx <= 0; bus_ack <= 1'b0;
    end else begin
      if (pl_valid && pl_ready) pl_idx <= pl_idx + 1;
      if (!rst_n) bus_ack <= 1'b0;
      else if (bus_req && !bus_ack) begin
        bus_ack <= 1'b1;
        if (log_n < 64) begin
          log_we[log_n] <= bus_we; log_addr[log_n] <= bus_addr; log_data[log_n] <= bus_wdata;
        end
        log_n <= log_n + 1;
        if (!bus_we && bus_addr == 4'h4) begin
          bus_rdata <= (poll_n < notready_n) ? 32'h0 : stat_final;
          poll_n <= poll_n + 1;
        end else if (!bus_we && bus_addr == 4'hC) begin
          bus_rdata <= resp[rd_i % 4];
          rd_i <= rd_i + 1;
        end else bus_rdata <= 32'h0;
      end else bus_ack <= 1'b0;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_entry(input int i, input logic we, input logic [3:0] a,
                           input logic [31:0] d, input string req);
    chk(i < log_n && log_we[i] == we && log_addr[i] == a && log_data[i] == d,
        req, $sformatf("log[%0d] we=%0b addr=%h", i, we, a), log_data[i], d);
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic launch(input int len, input int limit);
    @(negedge clk); clr_log = 1'b1;
    @(negedge clk); clr_log = 1'b0;
    chunk_dwords = 16'(len); poll_limit = limit; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done, req, "done reached", {31'b0, done}, 32'h1);
  endtask

  task automatic chk_request(input int len);
    chk_entry(0, 1'b1, 4'h8, HDR, "R3");
    chk_entry(1, 1'b1, 4'h8, 32'(len + 4), "R3");
    chk_entry(2, 1'b1, 4'h8, 32'h3, "R3");
    chk_entry(3, 1'b1, 4'h8, 32'h0, "R3");
    for (int i = 0; i < len; i++) chk_entry(4 + i, 1'b1, 4'h8, 32'hA000_0000 + i, "R4");
    chk_entry(4 + len, 1'b1, 4'h0, 32'h8000_0000, "R5");
  endtask

  task automatic chk_response(input int first);
    for (int k = 0; k < 4; k++) begin
      chk_entry(first + 2 * k, 1'b0, 4'hC, 32'h0, "R8");
      chk_entry(first + 2 * k + 1, 1'b1, 4'hC, 32'h0, "R8");
    end
  endtask

  task automatic t_reset;
    chk(!busy && !done && !bus_req && !pl_ready, "R1", "idle outputs after reset",
        {28'b0, busy, done, bus_req, pl_ready}, 32'h0);
  endtask

  task automatic t_basic;
    stall = 1'b1; notready_n = 2; stat_final = 32'h8000_0000;
    resp[0] = HDR; resp[1] = 4; resp[2] = 32'h40; resp[3] = 32'h1;
    launch(3, 1000); wait_done("R12");
    chk_request(3);
    for (int i = 0; i < 3; i++) chk_entry(8 + i, 1'b0, 4'h4, 32'h0, "R6");
    chk_response(11);
    chk(log_n == 19, "R8", "transfer count", log_n, 19);
    chk(outcome == 2'd0, "R10", "outcome ok", outcome, 0);
    chk(next_offset == 32'h40 && !staging_finished, "R9", "offset", next_offset, 32'h40);
    chk(!hdr_warn, "R11", "no warning", hdr_warn, 0);
    @(negedge clk);
    chk(!done && !busy && next_offset == 32'h40, "R12", "done single pulse and hold",
        {30'b0, done, busy}, 0);
    stall = 1'b0;
  endtask

  task automatic t_zero_len_end;
    notready_n = 0; stat_final = 32'h8000_0000;
    resp[0] = HDR; resp[1] = 4; resp[2] = 32'hFFFF_FFFF; resp[3] = 32'h2;
    launch(0, 1000); wait_done("R4");
    chk_request(0);
    chk_response(6);
    chk(staging_finished && next_offset == 32'hFFFF_FFFF, "R9", "end marker", next_offset, 32'hFFFF_FFFF);
    chk(outcome == 2'd0, "R10", "progress flag only is ok", outcome, 0);
  endtask

  task automatic t_err_flag;
    notready_n = 1;
    resp[0] = HDR; resp[1] = 4; resp[2] = 32'h80; resp[3] = 32'h5;
    launch(1, 1000); wait_done("R10");
    chk(outcome == 2'd1, "R10", "error flag fails", outcome, 1);
    chk(next_offset == 32'h80, "R9", "offset on fail", next_offset, 32'h80);
  endtask

  task automatic t_bad_hdr;
    notready_n = 0;
    resp[0] = 32'h1234_5678; resp[1] = 5; resp[2] = 32'h100; resp[3] = 32'h1;
    launch(2, 1000); wait_done("R11");
    chk(hdr_warn, "R11", "warning set", hdr_warn, 1);
    chk(outcome == 2'd0, "R11", "warning does not fail", outcome, 0);
  endtask

  task automatic t_dev_err;
    notready_n = 1; stat_final = 32'h8000_0004;
    launch(1, 1000); wait_done("R6");
    chk(outcome == 2'd3, "R6", "device error outcome", outcome, 3);
    chk(log_n == 8, "R6", "no response access", log_n, 8);
    chk_entry(7, 1'b0, 4'h4, 32'h0, "R6");
    stat_final = 32'h8000_0000;
  endtask

  task automatic t_timeout;
    notready_n = 1000;
    launch(1, 20); wait_done("R7");
    chk(outcome == 2'd2, "R7", "timeout outcome", outcome, 2);
    chk(log_n > 8, "R7", "polled several times", log_n, 9);
    chk_entry(log_n - 1, 1'b1, 4'h0, 32'h1, "R7");
    chk(rd_i == 0, "R7", "no response read", rd_i, 0);
  endtask

  task automatic t_ready_vs_expiry;
    notready_n = 0; stat_final = 32'h8000_0000;
    resp[0] = HDR; resp[1] = 4; resp[2] = 32'h20; resp[3] = 32'h1;
    launch(0, 1); wait_done("R7");
    chk(outcome == 2'd0, "R7", "ready wins over expired budget", outcome, 0);
    chk(log_n == 14, "R7", "no abort write", log_n, 14);
    chk_response(6);
  endtask

  task automatic t_busy_start;
    notready_n = 0;
    resp[0] = HDR; resp[1] = 4; resp[2] = 32'h8; resp[3] = 32'h1;
    launch(2, 1000);
    repeat (3) @(negedge clk);
    chunk_dwords = 16'd7; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done("R12");
    chk_entry(1, 1'b1, 4'h8, 32'd6, "R12");
    chk(log_n == 16, "R12", "original length kept", log_n, 16);
    repeat (4) @(negedge clk);
    chk(!busy && !bus_req, "R12", "ignored start launches nothing", {30'b0, busy, bus_req}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_zero_len_end();
    t_err_flag();
    t_bad_hdr();
    t_dev_err();
    t_timeout();
    t_ready_vs_expiry();
    t_busy_start();
    finish_up();
  end
endmodule